// File: doc/BRIEF.md
# Eight-Slot Sample Ring Buffer with Fill Interrupt

This block holds processed receiver sample sets between a signal-processing pipeline and a 16-bit host. Each set carries five words: in-phase, quadrature, magnitude, phase and frequency. The pipeline offers one set per cycle on a valid/ready stream. A set is stored only in a cycle where `in_valid` and `in_ready` are both high. `in_ready` drops while the ring is full, and an offered set is then not stored. The producer decides whether to hold it or drop it.

The host picks a field with a 3-bit select and reads it as two bytes on ports A (upper byte) and B (lower byte). It moves to the next stored set by presenting the advance code with the B enable low. The read and write pointers never hold the same slot. The read pointer rests one slot behind the write pointer when the ring is empty. Each advance is followed by a settling window during which the data-valid flag is low. A fill status is always visible. An interrupt is raised when a write lifts the fill level above a programmable threshold. A control strobe restarts the ring.

Top module: `sample_ring_buf`

## Requirements
- R1: After reset, `fill_lvl` is 0, `irq` is 0, `in_ready` is 1 and `data_valid` is 1. The write pointer is at slot 0 and the read pointer is at slot 7, so the first stored set is seen only after one advance.
- R2: The read and write pointers never point at the same slot.
- R3: A set is stored when `in_valid` and `in_ready` are both high at a clock edge, and `fill_lvl` then rises by one.
- R4: The ring is full when the write pointer is one slot behind the read pointer, which is 6 unread sets. While full, `in_ready` is 0, offered sets are not stored, and `fill_lvl` stays at 6.
- R5: The ring is empty when the read pointer is one slot behind the write pointer (`fill_lvl` 0). While empty, advance requests are ignored.
- R6: An advance request is `sel` = 7 with `oe_b_n` = 0. Each rising of that condition moves the read pointer one slot forward, once, however long the request is held. The sets come out in write order.
- R7: For the 4 clock cycles after an advance takes effect, `data_valid` is 0. It returns to 1 on the 4th edge after the advance.
- R8: `fill_lvl` equals (write pointer - read pointer - 1) mod 8.
- R9: `irq` is set by a write-only cycle that lifts `fill_lvl` from `irq_thresh` to `irq_thresh`+1. It clears in the cycle `fill_lvl` falls to `irq_thresh` or below.
- R10: A write and an advance in the same cycle are both carried out when neither the full rule nor the empty rule blocks them, and `fill_lvl` is then unchanged.
- R11: A one-cycle pulse on `ctl_clr` resets the write pointer to slot 0 and the read pointer to slot 7. This leaves the ring empty with `irq` at 0.
- R12: The select codes map to fields as follows: 0 in-phase, 1 quadrature, 2 magnitude, 3 phase, 4 frequency. Codes 5, 6 and 7 give zero. `aout` carries the upper byte of the field and `bout` the lower byte.
- R13: `aout` is zero while `oe_a_n` is 1, and `bout` is zero while `oe_b_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctl_clr | input | 1 | Control-register write strobe that restarts the ring |
| irq_thresh | input | 3 | Interrupt fill threshold |
| in_valid | input | 1 | Producer offers a sample set |
| in_ready | output | 1 | Ring can store a set (not full) |
| in_i | input | 16 | In-phase word |
| in_q | input | 16 | Quadrature word |
| in_mag | input | 16 | Magnitude word |
| in_phase | input | 16 | Phase word |
| in_freq | input | 16 | Frequency word |
| sel | input | 3 | Field select, or advance code 7 |
| oe_a_n | input | 1 | Port A enable, active low |
| oe_b_n | input | 1 | Port B enable, active low |
| aout | output | 8 | Upper byte of the selected field |
| bout | output | 8 | Lower byte of the selected field |
| data_valid | output | 1 | Output data settled after the last advance |
| fill_lvl | output | 3 | Count of unread sets |
| irq | output | 1 | Fill above threshold |

## Verification
The fill logic is driven through a walk that fills the ring to the blocked state, then drains it past empty, with one cycle that writes and advances together. This separates an off-by-one in the full or empty comparison from a fault in the interrupt edge. Held advance requests tell edge detection apart from level detection. Reading each field after successive advances shows the select map, the byte order and the write-to-read ordering. The clear strobe is applied while the interrupt is high.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
  parameter int unsigned FIELD_W = 16;
  localparam int unsigned BYTE_W = FIELD_W / 2;

  localparam logic [2:0] SEL_I     = 3'd0;
  localparam logic [2:0] SEL_Q     = 3'd1;
  localparam logic [2:0] SEL_MAG   = 3'd2;
  localparam logic [2:0] SEL_PHASE = 3'd3;
  localparam logic [2:0] SEL_FREQ  = 3'd4;
  localparam logic [2:0] SEL_ADV   = 3'd7;

  typedef struct packed {
    logic [FIELD_W-1:0] i;
    logic [FIELD_W-1:0] q;
    logic [FIELD_W-1:0] mag;
    logic [FIELD_W-1:0] phase;
    logic [FIELD_W-1:0] freq;
  } sample_t;
endpackage

// File: rtl/sbuf_ptrs.sv
module sbuf_ptrs #(
  parameter int unsigned PTR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_req,
  input  logic             rd_req,
  input  logic [PTR_W-1:0] thr,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [PTR_W-1:0] fill,
  output logic             full,
  output logic             wr_fire,
  output logic             rd_fire,
  output logic             irq
);
  localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

  logic             empty;
  logic [PTR_W-1:0] fill_nx;

  // Full/empty are one-ahead comparisons, so the pointers can never meet.
  assign full    = ((wr_ptr + ONE) == rd_ptr);
  assign empty   = ((rd_ptr + ONE) == wr_ptr);
  assign fill    = wr_ptr - rd_ptr - ONE;
  assign wr_fire = wr_req && !full && !clr;
  assign rd_fire = rd_req && !empty && !clr;

  always_comb begin
    fill_nx = fill;
    if (wr_fire && !rd_fire)      fill_nx = fill + ONE;
    else if (rd_fire && !wr_fire) fill_nx = fill - ONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '1;
      irq    <= 1'b0;
    end else begin
      if (wr_fire) wr_ptr <= wr_ptr + ONE;
      if (rd_fire) rd_ptr <= rd_ptr + ONE;
      if (fill_nx <= thr)
        irq <= 1'b0;
      else if (wr_fire && !rd_fire && (fill == thr))
        irq <= 1'b1;
    end
  end
endmodule

// File: rtl/sbuf_store.sv
module sbuf_store #(
  parameter int unsigned PTR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [PTR_W-1:0]  waddr,
  input  sbuf_pkg::sample_t wdata,
  input  logic [PTR_W-1:0]  raddr,
  output sbuf_pkg::sample_t rdata
);
  localparam int unsigned DEPTH = 1 << PTR_W;

  sbuf_pkg::sample_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/sbuf_settle.sv
module sbuf_settle #(
  parameter int unsigned SETTLE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic ready
);
  localparam int unsigned CNT_W = $clog2(SETTLE_CYC + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (start)        cnt <= CNT_W'(SETTLE_CYC);
    else if (cnt != '0)    cnt <= cnt - CNT_W'(1);
  end

  assign ready = (cnt == '0);
endmodule

// File: rtl/sbuf_outmux.sv
module sbuf_outmux (
  input  sbuf_pkg::sample_t            cur,
  input  logic [2:0]                   sel,
  input  logic                         oe_a_n,
  input  logic                         oe_b_n,
  output logic [sbuf_pkg::BYTE_W-1:0]  a_byte,
  output logic [sbuf_pkg::BYTE_W-1:0]  b_byte
);
  import sbuf_pkg::*;

  logic [FIELD_W-1:0] word;

  always_comb begin
    case (sel)
      SEL_I:     word = cur.i;
      SEL_Q:     word = cur.q;
      SEL_MAG:   word = cur.mag;
      SEL_PHASE: word = cur.phase;
      SEL_FREQ:  word = cur.freq;
      default:   word = '0;
    endcase
  end

  assign a_byte = oe_a_n ? '0 : word[FIELD_W-1 -: BYTE_W];
  assign b_byte = oe_b_n ? '0 : word[BYTE_W-1:0];
endmodule

// File: rtl/sample_ring_buf.sv
module sample_ring_buf #(
  parameter int unsigned PTR_W      = 3,
  parameter int unsigned SETTLE_CYC = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ctl_clr,
  input  logic [PTR_W-1:0]              irq_thresh,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [sbuf_pkg::FIELD_W-1:0]  in_i,
  input  logic [sbuf_pkg::FIELD_W-1:0]  in_q,
  input  logic [sbuf_pkg::FIELD_W-1:0]  in_mag,
  input  logic [sbuf_pkg::FIELD_W-1:0]  in_phase,
  input  logic [sbuf_pkg::FIELD_W-1:0]  in_freq,
  input  logic [2:0]                    sel,
  input  logic                          oe_a_n,
  input  logic                          oe_b_n,
  output logic [sbuf_pkg::BYTE_W-1:0]   aout,
  output logic [sbuf_pkg::BYTE_W-1:0]   bout,
  output logic                          data_valid,
  output logic [PTR_W-1:0]              fill_lvl,
  output logic                          irq
);
  import sbuf_pkg::*;

  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             full, wr_fire, rd_fire;
  logic             adv_lvl, adv_q, adv_req;
  sample_t          wdata, cur;

  // One advance per rising edge of the request condition.
  assign adv_lvl = (sel == SEL_ADV) && !oe_b_n;
  always_ff @(posedge clk) begin
    if (!rst_n) adv_q <= 1'b0;
    else        adv_q <= adv_lvl;
  end
  assign adv_req = adv_lvl && !adv_q;

  assign wdata = '{i: in_i, q: in_q, mag: in_mag, phase: in_phase, freq: in_freq};

  sbuf_ptrs #(.PTR_W(PTR_W)) u_ptrs (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (ctl_clr),
    .wr_req  (in_valid),
    .rd_req  (adv_req),
    .thr     (irq_thresh),
    .wr_ptr  (wr_ptr),
    .rd_ptr  (rd_ptr),
    .fill    (fill_lvl),
    .full    (full),
    .wr_fire (wr_fire),
    .rd_fire (rd_fire),
    .irq     (irq)
  );

  sbuf_store #(.PTR_W(PTR_W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_fire),
    .waddr (wr_ptr),
    .wdata (wdata),
    .raddr (rd_ptr),
    .rdata (cur)
  );

  sbuf_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk   (clk),
    .rst_n (rst_n),
    .start (rd_fire),
    .ready (data_valid)
  );

  sbuf_outmux u_mux (
    .cur    (cur),
    .sel    (sel),
    .oe_a_n (oe_a_n),
    .oe_b_n (oe_b_n),
    .a_byte (aout),
    .b_byte (bout)
  );

  assign in_ready = !full;
endmodule

// File: rtl/sbuf_checker.sv
module sbuf_checker #(
  parameter int unsigned PTR_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_clr,
  input logic             in_valid,
  input logic             in_ready,
  input logic             data_valid,
  input logic             irq,
  input logic [PTR_W-1:0] fill_lvl,
  input logic [PTR_W-1:0] wr_ptr,
  input logic [PTR_W-1:0] rd_ptr
);
  localparam int unsigned MAX_FILL = (1 << PTR_W) - 2;

  AST_PTRS_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ptr != rd_ptr); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready && !ctl_clr) |=> (wr_ptr == $past(wr_ptr))); // R4
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_lvl == '0 && !ctl_clr) |=> (rd_ptr == $past(rd_ptr))); // R5
  AST_SETTLE_HIDES: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_ptr != $past(rd_ptr)) && !$past(ctl_clr)) |-> !data_valid); // R7
  AST_FILL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fill_lvl) <= MAX_FILL); // R8
  AST_IRQ_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(in_valid && in_ready)); // R9
endmodule

bind sample_ring_buf sbuf_checker #(.PTR_W(PTR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctl_clr    (ctl_clr),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .data_valid (data_valid),
  .irq        (irq),
  .fill_lvl   (fill_lvl),
  .wr_ptr     (wr_ptr),
  .rd_ptr     (rd_ptr)
);

// File: tb/tb_sample_ring_buf.sv
module tb_sample_ring_buf;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_clr = 1'b0;
  logic [2:0]  irq_thresh = 3'd4;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_i = '0, in_q = '0, in_mag = '0, in_phase = '0, in_freq = '0;
  logic [2:0]  sel = 3'd0;
  logic        oe_a_n = 1'b1, oe_b_n = 1'b1;
  logic [7:0]  aout, bout;
  logic        data_valid;
  logic [2:0]  fill_lvl;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int seq = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sample_ring_buf dut (.*);

  // Vector: {op[1:0], fill[2:0], irq, ready}; op 0 write, 1 advance, 2 both. Threshold 4.
  localparam logic [6:0] VEC [18] = '{
    {2'd1, 3'd0, 1'b0, 1'b1}, {2'd0, 3'd1, 1'b0, 1'b1}, {2'd0, 3'd2, 1'b0, 1'b1},
    {2'd0, 3'd3, 1'b0, 1'b1}, {2'd0, 3'd4, 1'b0, 1'b1}, {2'd0, 3'd5, 1'b1, 1'b1},
    {2'd0, 3'd6, 1'b1, 1'b0}, {2'd0, 3'd6, 1'b1, 1'b0}, {2'd1, 3'd5, 1'b1, 1'b1},
    {2'd1, 3'd4, 1'b0, 1'b1}, {2'd0, 3'd5, 1'b1, 1'b1}, {2'd2, 3'd5, 1'b1, 1'b1},
    {2'd1, 3'd4, 1'b0, 1'b1}, {2'd1, 3'd3, 1'b0, 1'b1}, {2'd1, 3'd2, 1'b0, 1'b1},
    {2'd1, 3'd1, 1'b0, 1'b1}, {2'd1, 3'd0, 1'b0, 1'b1}, {2'd1, 3'd0, 1'b0, 1'b1}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Drive one operation for one cycle, then one idle cycle.
  task automatic step(input bit do_wr, input bit do_adv);
    @(negedge clk);
    in_valid = do_wr;
    in_i = 16'h1100 + 16'(seq); in_q = 16'h2200 + 16'(seq);
    in_mag = 16'h3300 + 16'(seq); in_phase = 16'h4400 + 16'(seq);
    in_freq = 16'h5500 + 16'(seq);
    if (do_adv) begin sel = 3'd7; oe_b_n = 1'b0; end
    @(negedge clk);
    in_valid = 1'b0; sel = 3'd0; oe_b_n = 1'b1;
    if (do_wr) seq++;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1; seq = 0;
    @(negedge clk);
  endtask

  task automatic wait_settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R1 fill", fill_lvl, 0);
    chk("R1 irq", irq, 0);
    chk("R1 in_ready", in_ready, 1);
    chk("R1 data_valid", data_valid, 1);
    chk("R13 aout disabled", aout, 0);

    // Table walk: R3 R4 R5 R8 R9 R10
    for (int n = 0; n < 18; n++) begin
      logic [6:0] v;
      v = VEC[n];
      step(v[6:5] != 2'd1, v[6:5] != 2'd0);
      chk($sformatf("R8/R4/R5 fill vec %0d", n), fill_lvl, v[4:2]);
      chk($sformatf("R9 irq vec %0d", n), irq, v[1]);
      chk($sformatf("R4/R3 ready vec %0d", n), in_ready, v[0]);
    end

    // Field select, ordering and settle
    do_reset();
    step(1, 0); step(1, 0); step(1, 0);
    step(0, 1);
    chk("R7 valid low after advance", data_valid, 0);
    repeat (3) @(negedge clk);
    chk("R7 valid low 4th cycle", data_valid, 0);
    @(negedge clk);
    chk("R7 valid back", data_valid, 1);
    oe_a_n = 1'b0; oe_b_n = 1'b0;
    for (int s = 0; s < 5; s++) begin
      sel = 3'(s); #1;
      chk($sformatf("R12 aout sel %0d", s), aout, 8'h11 * (s + 1));
      chk($sformatf("R12 bout sel %0d", s), bout, 0);
    end
    sel = 3'd5; #1;
    chk("R12 code 5 zero", {aout, bout}, 0);
    sel = 3'd0; oe_a_n = 1'b1; #1;
    chk("R13 aout off", aout, 0);
    chk("R13 bout on", bout, 0);
    oe_b_n = 1'b1; oe_a_n = 1'b0; #1;
    chk("R13 bout off", bout, 0);
    chk("R13 aout on", aout, 8'h11);
    oe_a_n = 1'b1;
    step(0, 1); wait_settle();
    oe_b_n = 1'b0; #1;
    chk("R6 second set in order", bout, 1);
    oe_b_n = 1'b1;

    // Held request advances once (fill 1 -> write 2 -> 3, hold -> 2)
    step(1, 0); step(1, 0);
    chk("R3 fill before hold", fill_lvl, 3);
    @(negedge clk); sel = 3'd7; oe_b_n = 1'b0;
    repeat (3) @(negedge clk);
    sel = 3'd0; oe_b_n = 1'b1;
    @(negedge clk);
    chk("R6 held request one step", fill_lvl, 2);

    // Raise irq, then clear strobe
    step(1, 0); step(1, 0); step(1, 0);
    chk("R9 irq raised at 5", irq, 1);
    @(negedge clk); ctl_clr = 1'b1;
    @(negedge clk); ctl_clr = 1'b0;
    chk("R11 fill after clear", fill_lvl, 0);
    chk("R11 irq after clear", irq, 0);
    chk("R11 ready after clear", in_ready, 1);
    step(0, 1);
    chk("R11 empty after clear ignores advance", fill_lvl, 0);
    chk("R2 clear keeps settle idle", data_valid, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule